// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block produces the 16x oversampling strobes that a serial transmitter and receiver use to time their bits. The strobes come from counter overflows. Two timers are inside. The narrow one is an auto-reload counter. It is clocked by the system clock, by the system clock divided by twelve, or by the rising edges of an external clock pin. The wide one counts system clocks and reloads from its own reload word. A rate bit decides whether the narrow timer's overflows pass straight through or only every second one.

The transmit strobe and the receive strobe each choose their own timer. One side can therefore run from the narrow path while the other runs from the wide path. Each timer has a run input. While a timer is stopped it holds its reload value. Starting it then gives a known first period. The user changes the configuration by stopping the timers, writing the new values and starting them again.

Top module: `baud_tick_gen`

## Requirements
- R1: The narrow timer overflows once every (256 - `t8_reload`) input enables. It passes its maximum value and then loads `t8_reload` again. With `dbl_rate`=1 and the system-clock source, the strobe period is 256 - `t8_reload` cycles.
- R2: With `t8_src`=2'b00 the narrow timer counts one enable every 12 system clocks, from a free-running divider.
- R3: With `t8_src`=2'b10 the narrow timer counts one enable per rising edge of `ext_clk`. The edge is found after a two-flop synchroniser. With `t8_src`=2'b01 it counts every system clock.
- R4: With `t8_src`=2'b11 the narrow timer does not count, and no strobe comes from it.
- R5: With `dbl_rate`=0 only every second narrow-timer overflow becomes a strobe, so the period doubles. With `dbl_rate`=1 every overflow becomes a strobe.
- R6: The wide timer gives a strobe every (65536 - `t16_reload`) system clocks. `dbl_rate` has no effect on this period.
- R7: `tx_sel` and `rx_sel` pick the source of `tx_tick` and `rx_tick` separately. The value 0 selects the narrow timer and 1 selects the wide timer.
- R8: After reset both strobes are low. While a timer's run input is low, that timer holds its reload value, its halving phase is cleared and it gives no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External count clock, asynchronous to clk |
| t8_src | input | 2 | Narrow timer clock source: 00 sys/12, 01 sys, 10 external, 11 off |
| t8_reload | input | 8 | Narrow timer reload value |
| t8_run | input | 1 | Narrow timer run enable |
| dbl_rate | input | 1 | 1: every narrow overflow gives a strobe; 0: every second one does |
| t16_reload | input | 16 | Wide timer reload value |
| t16_run | input | 1 | Wide timer run enable |
| tx_sel | input | 1 | Transmit strobe source (0 narrow, 1 wide) |
| rx_sel | input | 1 | Receive strobe source (0 narrow, 1 wide) |
| tx_tick | output | 1 | Transmit 16x strobe, one cycle per event |
| rx_tick | output | 1 | Receive 16x strobe, one cycle per event |

## Verification
The bench targets these corner cases:

- **Reload of 0xFF with the fast rate.** The strobe must then fire on every cycle. A counter that spends a cycle reloading would instead show a period of two.
- **Reload of zero at the halved rate.** The period is 512 cycles. A halving flop that toggles at the wrong time would give either 256 or an irregular period.
- **Divide-by-12 and external sources.** These are measured against periods that are multiples of the source period. A divider with the wrong modulus, or an edge detector that fires on both edges, would show up as a scaled period.
- **Wide-timer reload of 0xFFFF.** This case checks the wide path at a one-cycle period.
- **Off source and stopped timers.** These are watched for stray strobes.
- **Crossed transmit and receive selects.** These catch a design whose two selects are tied together.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

   typedef enum logic [1:0] {
      SRC_DIV12 = 2'b00,
      SRC_SYS   = 2'b01,
      SRC_EXT   = 2'b10,
      SRC_OFF   = 2'b11
   } clk_src_e;

   localparam logic PATH_NARROW = 1'b0;
   localparam logic PATH_WIDE   = 1'b1;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic pulse
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("tick_prescaler: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign pulse = (cnt_q == LAST);

   // R2
   presc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

endmodule

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tick_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_in};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;

   // R3
   edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/reload_counter.sv
module reload_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         en,
   input  logic [W-1:0] reload,
   output logic         ovf
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   if (W < 2) begin : g_bad_width
      $error("reload_counter: W must be at least 2");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run)          cnt_q <= reload;
      else if (en) begin
         if (cnt_q == TOP)    cnt_q <= reload;
         else                 cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ovf = run & en & (cnt_q == TOP);

   // R1
   reload_after_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> cnt_q == $past(reload));

   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !en) |=> $stable(cnt_q));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_tick_pkg::*;
#(
   parameter int W8      = 8,
   parameter int W16     = 16,
   parameter int PRE_DIV = 12,
   parameter int SYNC_N  = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ext_clk,
   input  logic [1:0]     t8_src,
   input  logic [W8-1:0]  t8_reload,
   input  logic           t8_run,
   input  logic           dbl_rate,
   input  logic [W16-1:0] t16_reload,
   input  logic           t16_run,
   input  logic           tx_sel,
   input  logic           rx_sel,
   output logic           tx_tick,
   output logic           rx_tick
);
   if (W16 < W8) begin : g_bad_widths
      $error("baud_tick_gen: W16 must not be narrower than W8");
   end

   logic pre_pulse, ext_rise, en8, ovf8, ovf16, half_q, tick8;
   logic tx_d, rx_d;
   clk_src_e src;

   tick_prescaler #(.DIV(PRE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .pulse(pre_pulse));

   tick_edge_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise));

   assign src = clk_src_e'(t8_src);

   always_comb begin
      case (src)
         SRC_DIV12: en8 = pre_pulse;
         SRC_SYS:   en8 = 1'b1;
         SRC_EXT:   en8 = ext_rise;
         default:   en8 = 1'b0;
      endcase
   end

   reload_counter #(.W(W8)) u_narrow (
      .clk(clk), .rst_n(rst_n), .run(t8_run), .en(en8),
      .reload(t8_reload), .ovf(ovf8));

   reload_counter #(.W(W16)) u_wide (
      .clk(clk), .rst_n(rst_n), .run(t16_run), .en(1'b1),
      .reload(t16_reload), .ovf(ovf16));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      half_q <= 1'b0;
      else if (!t8_run) half_q <= 1'b0;
      else if (ovf8)   half_q <= ~half_q;
   end

   assign tick8 = ovf8 & (dbl_rate | half_q);

   assign tx_d = (tx_sel == PATH_WIDE) ? ovf16 : tick8;
   assign rx_d = (rx_sel == PATH_WIDE) ? ovf16 : tick8;

   if (OUT_REG) begin : g_out_reg
      logic tx_q, rx_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tx_q <= 1'b0;
            rx_q <= 1'b0;
         end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
         end
      end
      assign tx_tick = tx_q;
      assign rx_tick = rx_q;

      // R8
      stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!t8_run && !t16_run) |=> (!tx_tick && !rx_tick));
   end else begin : g_out_comb
      assign tx_tick = tx_d;
      assign rx_tick = rx_d;

      // R8
      stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!t8_run && !t16_run) |-> (!tx_tick && !rx_tick));
   end

endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_clk = 1'b0;
   logic [1:0]  t8_src = 2'b01;
   logic [7:0]  t8_reload = 8'h00;
   logic        t8_run = 1'b0;
   logic        dbl_rate = 1'b0;
   logic [15:0] t16_reload = 16'hFFFF;
   logic        t16_run = 1'b0;
   logic        tx_sel = 1'b0;
   logic        rx_sel = 1'b1;
   logic        tx_tick, rx_tick;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   localparam int EXT_HALF = 3;

   baud_tick_gen u0 (
      .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .t8_src(t8_src),
      .t8_reload(t8_reload), .t8_run(t8_run), .dbl_rate(dbl_rate),
      .t16_reload(t16_reload), .t16_run(t16_run), .tx_sel(tx_sel),
      .rx_sel(rx_sel), .tx_tick(tx_tick), .rx_tick(rx_tick));

   always #5 clk = ~clk;

   always begin
      repeat (EXT_HALF) @(negedge clk);
      ext_clk = ~ext_clk;
   end

   function automatic int src_mult(input logic [1:0] s);
      case (s)
         2'b00:   return 12;
         2'b01:   return 1;
         2'b10:   return 2 * EXT_HALF;
         default: return 0;
      endcase
   endfunction

   function automatic int exp8(input logic [7:0] r, input logic [1:0] s, input logic d);
      return (256 - int'(r)) * src_mult(s) * (d ? 1 : 2);
   endfunction

   function automatic int exp16(input logic [15:0] r);
      return 65536 - int'(r);
   endfunction

   function automatic logic pick(input bit use_rx);
      return use_rx ? rx_tick : tx_tick;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic setup(input logic [1:0] s, input logic [7:0] r8, input logic d,
                        input logic [15:0] r16, input logic txs, input logic rxs);
      @(negedge clk);
      t8_run = 1'b0;
      t16_run = 1'b0;
      repeat (2) @(negedge clk);
      t8_src = s; t8_reload = r8; dbl_rate = d;
      t16_reload = r16; tx_sel = txs; rx_sel = rxs;
      @(negedge clk);
      t8_run = 1'b1;
      t16_run = 1'b1;
   endtask

   task automatic wait_tick(input bit use_rx, input int lim);
      int t = 0;
      do begin
         @(negedge clk);
         t++;
      end while (!pick(use_rx) && t < lim);
   endtask

   task automatic measure(input bit use_rx, input int expv, input int n, input string req);
      int lim = expv * 3 + 200;
      wait_tick(use_rx, lim);
      wait_tick(use_rx, lim);
      for (int i = 0; i < n; i++) begin
         int t = 0;
         do begin
            @(negedge clk);
            t++;
         end while (!pick(use_rx) && t < lim);
         check(t == expv, req, t, expv);
      end
   endtask

   task automatic count_quiet(input int cycles, input string req);
      int seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (tx_tick || rx_tick) seen++;
      end
      check(seen == 0, req, seen, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int unsigned seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      // R8: strobes low in reset
      check(tx_tick == 1'b0 && rx_tick == 1'b0, "R8 reset", int'(tx_tick | rx_tick), 0);
      rst_n = 1'b1;
      count_quiet(40, "R8 idle after reset");

      // R1: system clock, fast rate
      setup(2'b01, 8'hF0, 1'b1, 16'hFFF0, 1'b0, 1'b1);
      measure(1'b0, exp8(8'hF0, 2'b01, 1'b1), 3, "R1 narrow period");
      // R1 corner: reload 0xFF fires every cycle
      setup(2'b01, 8'hFF, 1'b1, 16'hFFF0, 1'b0, 1'b1);
      measure(1'b0, 1, 4, "R1 reload max");
      // R5: halved rate, reload 0xFF and 0x00
      setup(2'b01, 8'hFF, 1'b0, 16'hFFF0, 1'b0, 1'b1);
      measure(1'b0, 2, 4, "R5 halved max");
      setup(2'b01, 8'h00, 1'b0, 16'hFFF0, 1'b0, 1'b1);
      measure(1'b0, exp8(8'h00, 2'b01, 1'b0), 2, "R5 halved zero");
      // R2: divide by twelve
      setup(2'b00, 8'hF8, 1'b1, 16'hFFF0, 1'b0, 1'b1);
      measure(1'b0, exp8(8'hF8, 2'b00, 1'b1), 3, "R2 div12");
      // R3: external clock
      setup(2'b10, 8'hF4, 1'b0, 16'hFFF0, 1'b0, 1'b1);
      measure(1'b0, exp8(8'hF4, 2'b10, 1'b0), 3, "R3 external");
      // R4: source off
      setup(2'b11, 8'hFF, 1'b1, 16'hFFF0, 1'b0, 1'b0);
      count_quiet(3000, "R4 source off");
      // R6: wide path, dbl_rate has no effect
      setup(2'b01, 8'hF0, 1'b0, 16'hFFE0, 1'b1, 1'b1);
      measure(1'b0, exp16(16'hFFE0), 3, "R6 wide slow flag");
      setup(2'b01, 8'hF0, 1'b1, 16'hFFE0, 1'b1, 1'b1);
      measure(1'b1, exp16(16'hFFE0), 3, "R6 wide fast flag");
      setup(2'b01, 8'hF0, 1'b1, 16'hFFFF, 1'b1, 1'b1);
      measure(1'b1, 1, 3, "R6 wide reload max");
      // R7: crossed selects
      setup(2'b01, 8'hE0, 1'b1, 16'hFFC8, 1'b0, 1'b1);
      measure(1'b0, exp8(8'hE0, 2'b01, 1'b1), 2, "R7 tx narrow");
      measure(1'b1, exp16(16'hFFC8), 2, "R7 rx wide");
      setup(2'b01, 8'hE0, 1'b1, 16'hFFC8, 1'b1, 1'b0);
      measure(1'b0, exp16(16'hFFC8), 2, "R7 tx wide");
      measure(1'b1, exp8(8'hE0, 2'b01, 1'b1), 2, "R7 rx narrow");

      // random mix
      for (int k = 0; k < 8; k++) begin
         logic [1:0]  s   = 2'($urandom % 3);
         logic [7:0]  r8  = 8'hF0 | 8'($urandom % 16);
         logic        d   = 1'($urandom % 2);
         logic [15:0] r16 = 16'hFFFF - 16'($urandom % 300);
         logic        txs = 1'($urandom % 2);
         logic        rxs = ~txs;
         setup(s, r8, d, r16, txs, rxs);
         // R7 R5 R6: each side against its own source
         measure(1'b0, txs ? exp16(r16) : exp8(r8, s, d), 2, "R7 random tx");
         measure(1'b1, rxs ? exp16(r16) : exp8(r8, s, d), 2, "R7 random rx");
      end

      // R8: stopping silences both strobes
      @(negedge clk);
      t8_run = 1'b0;
      t16_run = 1'b0;
      @(negedge clk);
      count_quiet(600, "R8 stopped");

      done = 1'b1;
      if (seed == 32'hFFFF_FFFF) $display("seed edge");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule